// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This block is a register-mapped timekeeping core. It holds two 32-bit seconds counters that move in opposite directions: an ascending count and a descending count that software keeps as its bitwise complement. Each pulse on a one-cycle `tick` input, normally derived from a 1 Hz source, advances both counters while counting is enabled. Two match registers are compared against the ascending count. A hit sets a sticky status flag that software clears by writing a 1 to it.

The flags drive two outputs. The interrupt line rises when a flag and its interrupt enable are both set. A separate power-on switch output can be driven by either match flag, each behind its own enable, or forced high from the control register. The switch output also sets a third sticky flag of its own. A plain key register lets boot software record that first-time setup has been done. A held soft-reset bit clears the counters and the flags but keeps the match and key registers. Software loads the time by halting the counters, writing the ascending counter and then releasing the halt.

Top module: `sec_rtc_top`

## Requirements
- R1: After reset both counters, the control register, the status register and the key register read 0, both match registers read 0xFFFFFFFF, and `irqOut` and `powerSw` are low.
- R2: The byte offsets are 0x00 ascending count, 0x04 descending count, 0x08 match A, 0x0C match B, 0x10 control, 0x14 status and 0x18 key. Match and key registers read back what was written. Control bit 5 is reserved, ignores writes and reads 0.
- R3: While control bit 6 (halt) is set, a write to 0x00 loads the ascending counter with the data and the descending counter with 0xFFFFFFFF minus the data, and a write to 0x04 loads only the descending counter. While the halt bit is clear, writes to both counters are ignored.
- R4: On a tick with halt clear and soft reset clear, the ascending counter adds 1 and the descending counter subtracts 1. Both wrap modulo 2^32.
- R5: On every tick without soft reset, status bit 0 (bit 1) is set if the ascending count after that tick equals match A (match B). The flag therefore sets again on each tick for as long as the equality holds, for example while the counters are halted.
- R6: A match register that holds 0xFFFFFFFF never sets its flag, even when the ascending count is 0xFFFFFFFF.
- R7: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. A set event in the same cycle takes priority over the clear.
- R8: `irqOut` is high exactly when (status bit 0 and control bit 0) or (status bit 1 and control bit 1) are set.
- R9: `powerSw` is high when control bit 7 is set, when status bit 0 and control bit 2 are set, or when status bit 1 and control bit 3 are set.
- R10: Status bit 2 is set on the clock edge after `powerSw` is observed high, and stays set while `powerSw` remains high, even if software writes a 1 to clear it.
- R11: While control bit 4 (soft reset) is set, both counters and all status bits are held at 0 and ticks are ignored. The match and key registers keep their values, and counting resumes once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle seconds pulse |
| busAddr | input | 5 | Byte offset of the register accessed |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Match interrupt request |
| powerSw | output | 1 | Power-on switch output |

## Verification
The hardest state to reach is a match flag that sets again without any change of count, because the count is normally past the match by the next tick. The stimulus first halts the counters, then loads the ascending count equal to a match register and ticks. It clears the flag and ticks again to see it return. The same halted setup lets the bench place the count at 0xFFFFFFFF against an all-ones match to show that the sentinel never fires. It is also used to raise the switch output from a match and then try to clear the switch flag while the output is still high.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  localparam int NUM_MATCH = 2;
  localparam int CTRL_W    = 8;
  localparam int STAT_W    = 3;

  // byte offsets
  localparam int OFS_UP    = 'h00;
  localparam int OFS_DN    = 'h04;
  localparam int OFS_MATCH = 'h08;  // match i at OFS_MATCH + 4*i
  localparam int OFS_CTRL  = 'h10;
  localparam int OFS_STAT  = 'h14;
  localparam int OFS_KEY   = 'h18;

  // control bits
  localparam int CB_IRQ0  = 0;   // irq enable for match i at CB_IRQ0 + i
  localparam int CB_SW0   = 2;   // switch enable for match i at CB_SW0 + i
  localparam int CB_SRST  = 4;
  localparam int CB_HALT  = 6;
  localparam int CB_FORCE = 7;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hDF;

  // status bits
  localparam int SB_SW = 2;       // match i flag at bit i

  typedef struct packed {
    logic clear;      // soft reset held
    logic step;       // advance both counters
    logic evalMatch;  // compare on this tick
    logic loadUp;     // load ascending + complement
    logic loadDn;     // load descending only
  } cnt_cmd_t;

endpackage

// File: rtl/sec_rtc_datapath.sv
module sec_rtc_datapath
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  cnt_cmd_t                      cmd,
  input  logic [DATA_W-1:0]             loadVal,
  input  logic [NUM_MATCH-1:0][DATA_W-1:0] matchVal,
  output logic [DATA_W-1:0]             upCnt,
  output logic [DATA_W-1:0]             dnCnt,
  output logic [NUM_MATCH-1:0]          hit
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic [DATA_W-1:0] upNext;

  // count value that this tick produces
  assign upNext = cmd.step ? (upCnt + ONE) : upCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upCnt <= '0;
      dnCnt <= '0;
    end else if (cmd.clear) begin
      upCnt <= '0;
      dnCnt <= '0;
    end else if (cmd.loadUp) begin
      upCnt <= loadVal;
      dnCnt <= ALL_ONES - loadVal;
    end else if (cmd.loadDn) begin
      dnCnt <= loadVal;
    end else if (cmd.step) begin
      upCnt <= upCnt + ONE;
      dnCnt <= dnCnt - ONE;
    end
  end

  // one comparator per match register; all-ones disables it
  for (genvar gi = 0; gi < NUM_MATCH; gi++) begin : g_cmp
    assign hit[gi] = cmd.evalMatch && (matchVal[gi] != ALL_ONES)
                     && (upNext == matchVal[gi]);
  end

endmodule

// File: rtl/sec_rtc_ctrl.sv
module sec_rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic                             busWe,
  input  logic [DATA_W-1:0]                busWdata,
  input  logic [NUM_MATCH-1:0]             hit,
  input  logic [DATA_W-1:0]                upCnt,
  input  logic [DATA_W-1:0]                dnCnt,
  output cnt_cmd_t                         cmd,
  output logic [NUM_MATCH-1:0][DATA_W-1:0] matchVal,
  output logic [CTRL_W-1:0]                ctrlBits,
  output logic [STAT_W-1:0]                statusBits,
  output logic [DATA_W-1:0]                busRdata,
  output logic                             irqOut,
  output logic                             powerSw
);

  localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(OFS_UP);
  localparam logic [ADDR_W-1:0] A_DN   = ADDR_W'(OFS_DN);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);

  logic [DATA_W-1:0]    keyReg;
  logic [NUM_MATCH-1:0] irqTerm, swTerm;
  logic [STAT_W-1:0]    setVec, clrVec;
  logic                 softRst, halted;

  assign softRst = ctrlBits[CB_SRST];
  assign halted  = ctrlBits[CB_HALT];

  // strobes to the datapath
  always_comb begin
    cmd.clear     = softRst;
    cmd.step      = tick && !halted && !softRst;
    cmd.evalMatch = tick && !softRst;
    cmd.loadUp    = busWe && (busAddr == A_UP) && halted && !softRst;
    cmd.loadDn    = busWe && (busAddr == A_DN) && halted && !softRst;
  end

  // match registers, one per comparator
  for (genvar gi = 0; gi < NUM_MATCH; gi++) begin : g_match
    localparam logic [ADDR_W-1:0] A_M = ADDR_W'(OFS_MATCH + 4 * gi);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          matchVal[gi] <= '1;
      else if (busWe && (busAddr == A_M))  matchVal[gi] <= busWdata;
    end
    assign irqTerm[gi] = statusBits[gi] && ctrlBits[CB_IRQ0 + gi];
    assign swTerm[gi]  = statusBits[gi] && ctrlBits[CB_SW0 + gi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctrlBits <= '0;
    else if (busWe && (busAddr == A_CTRL))  ctrlBits <= busWdata[CTRL_W-1:0] & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            keyReg <= '0;
    else if (busWe && (busAddr == A_KEY))  keyReg <= busWdata;
  end

  // sticky flags: set wins over write-1-to-clear
  assign clrVec = (busWe && (busAddr == A_STAT)) ? busWdata[STAT_W-1:0] : '0;
  assign setVec = {powerSw, hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       statusBits <= '0;
    else if (softRst) statusBits <= '0;
    else              statusBits <= (statusBits & ~clrVec) | setVec;
  end

  assign irqOut  = |irqTerm;
  assign powerSw = ctrlBits[CB_FORCE] || (|swTerm);

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_UP:    busRdata = upCnt;
      A_DN:    busRdata = dnCnt;
      A_CTRL:  busRdata = DATA_W'(ctrlBits);
      A_STAT:  busRdata = DATA_W'(statusBits);
      A_KEY:   busRdata = keyReg;
      default: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (busAddr == ADDR_W'(OFS_MATCH + 4 * i)) busRdata = matchVal[i];
      end
    endcase
  end

endmodule

// File: rtl/sec_rtc_top.sv
module sec_rtc_top
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              powerSw
);

  cnt_cmd_t                         cmd;
  logic [NUM_MATCH-1:0][DATA_W-1:0] matchVal;
  logic [NUM_MATCH-1:0]             hit;
  logic [DATA_W-1:0]                upCnt, dnCnt;
  logic [CTRL_W-1:0]                ctrlBits;
  logic [STAT_W-1:0]                statusBits;

  sec_rtc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .hit(hit), .upCnt(upCnt), .dnCnt(dnCnt),
    .cmd(cmd), .matchVal(matchVal), .ctrlBits(ctrlBits), .statusBits(statusBits),
    .busRdata(busRdata), .irqOut(irqOut), .powerSw(powerSw)
  );

  sec_rtc_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .loadVal(busWdata),
    .matchVal(matchVal), .upCnt(upCnt), .dnCnt(dnCnt), .hit(hit)
  );

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] upCnt,
  input logic [DATA_W-1:0] dnCnt,
  input logic [DATA_W-1:0] matchA,
  input logic [CTRL_W-1:0] ctrlBits,
  input logic [STAT_W-1:0] statusBits,
  input logic              irqOut,
  input logic              powerSw
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  // R3: a halted load of the ascending count leaves the pair complementary
  a_r3_complement_load: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFS_UP) && ctrlBits[CB_HALT] && !ctrlBits[CB_SRST])
    |=> ((upCnt ^ dnCnt) == ALL_ONES));

  // R4: a counting tick advances the ascending count by one
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrlBits[CB_HALT] && !ctrlBits[CB_SRST])
    |=> (upCnt == DATA_W'($past(upCnt) + DATA_W'(1))));

  // R6: the match A flag never rises against an all-ones match value
  a_r6_sentinel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusBits[0]) |-> ($past(matchA) != ALL_ONES));

  // R8: the interrupt needs a latched match flag
  a_r8_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (statusBits[0] || statusBits[1]));

  // R10: the switch output latches its flag one edge later
  a_r10_switch_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (powerSw && !ctrlBits[CB_SRST]) |=> statusBits[SB_SW]);

  // R11: soft reset empties counters and flags
  a_r11_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlBits[CB_SRST] |=> (upCnt == '0 && dnCnt == '0 && statusBits == '0));

endmodule

bind sec_rtc_top sec_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busWe(busWe), .busAddr(busAddr),
  .upCnt(upCnt), .dnCnt(dnCnt), .matchA(matchVal[0]), .ctrlBits(ctrlBits),
  .statusBits(statusBits), .irqOut(irqOut), .powerSw(powerSw)
);

// File: tb/sec_rtc_top_tb_top.sv
module sec_rtc_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 5;

  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_TK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 8'h00, 32'h0,        4'd1},  // R1
    '{OP_RD, 8'h04, 32'h0,        4'd1},  // R1
    '{OP_RD, 8'h08, 32'hFFFFFFFF, 4'd1},  // R1
    '{OP_RD, 8'h0C, 32'hFFFFFFFF, 4'd1},  // R1
    '{OP_RD, 8'h10, 32'h0,        4'd1},  // R1
    '{OP_RD, 8'h14, 32'h0,        4'd1},  // R1
    '{OP_RD, 8'h18, 32'h0,        4'd1},  // R1
    '{OP_WR, 8'h18, 32'hB5C13F27, 4'd2},  // R2 key
    '{OP_RD, 8'h18, 32'hB5C13F27, 4'd2},
    '{OP_WR, 8'h10, 32'h6F,       4'd2},  // R2 reserved bit 5
    '{OP_RD, 8'h10, 32'h4F,       4'd2},
    '{OP_WR, 8'h10, 32'h40,       4'd3},  // halt
    '{OP_WR, 8'h00, 32'd100,      4'd3},  // R3 load
    '{OP_RD, 8'h00, 32'd100,      4'd3},
    '{OP_RD, 8'h04, 32'hFFFFFF9B, 4'd3},
    '{OP_WR, 8'h04, 32'h10,       4'd3},
    '{OP_RD, 8'h04, 32'h10,       4'd3},
    '{OP_RD, 8'h00, 32'd100,      4'd3},
    '{OP_WR, 8'h00, 32'd100,      4'd3},
    '{OP_WR, 8'h08, 32'd102,      4'd5},
    '{OP_WR, 8'h10, 32'h01,       4'd4},  // count, irq A
    '{OP_TK, 8'h00, 32'h0,        4'd4},
    '{OP_RD, 8'h00, 32'd101,      4'd4},  // R4
    '{OP_RD, 8'h04, 32'hFFFFFF9A, 4'd4},
    '{OP_RD, 8'h14, 32'h0,        4'd5},
    '{OP_TK, 8'h00, 32'h0,        4'd5},
    '{OP_RD, 8'h14, 32'h1,        4'd5},  // R5 match at 102
    '{OP_WR, 8'h00, 32'd5,        4'd3},  // ignored while counting
    '{OP_RD, 8'h00, 32'd102,      4'd3},
    '{OP_WR, 8'h14, 32'h0,        4'd7},  // R7 zero write no effect
    '{OP_RD, 8'h14, 32'h1,        4'd7},
    '{OP_WR, 8'h14, 32'h1,        4'd7},
    '{OP_RD, 8'h14, 32'h0,        4'd7},
    '{OP_TK, 8'h00, 32'h0,        4'd5},
    '{OP_RD, 8'h00, 32'd103,      4'd4},
    '{OP_RD, 8'h14, 32'h0,        4'd5},
    '{OP_RD, 8'h04, 32'hFFFFFF98, 4'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          irqOut, powerSw;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sec_rtc_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .powerSw(powerSw)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; busWe = 1'b0; tick = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a[AW-1:0]; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    busAddr = a[AW-1:0];
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R1 irqOut after reset", DW'(irqOut), 0);
    check("R1 powerSw after reset", DW'(powerSw), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR: wr(VECS[i].addr, VECS[i].data);
        OP_TK: pulse();
        default: rd(VECS[i].addr, VECS[i].data, $sformatf("R%0d vec %0d", VECS[i].req, i));
      endcase
    end
    check("R8 irqOut low after clear", DW'(irqOut), 0);

    // R5 / R8: re-latch while halted at the match value
    do_reset();
    wr(8'h10, 32'h41);
    wr(8'h00, 32'd50);
    wr(8'h08, 32'd50);
    pulse();
    check("R8 irqOut on flag A", DW'(irqOut), 1);
    wr(8'h14, 32'h1);
    rd(8'h14, 32'h0, "R7 flag cleared");
    check("R8 irqOut follows flag", DW'(irqOut), 0);
    pulse();
    rd(8'h14, 32'h1, "R5 flag re-latches on held match");
    wr(8'h10, 32'h40);
    check("R8 irqOut masked by enable", DW'(irqOut), 0);

    // R5 match B
    wr(8'h0C, 32'd50);
    wr(8'h14, 32'h3);
    pulse();
    rd(8'h14, 32'h3, "R5 both flags on equal match values");

    // R6 all-ones sentinel
    wr(8'h08, 32'hFFFFFFFF);
    wr(8'h0C, 32'hFFFFFFFF);
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h14, 32'h7);
    pulse();
    rd(8'h14, 32'h0, "R6 sentinel never fires");

    // R4 wrap
    wr(8'h10, 32'h00);
    pulse();
    rd(8'h00, 32'h0, "R4 ascending wraps");
    rd(8'h04, 32'hFFFFFFFF, "R4 descending wraps");

    // R9 / R10 forced switch
    do_reset();
    wr(8'h10, 32'h80);
    check("R9 forced switch high", DW'(powerSw), 1);
    idle();
    rd(8'h14, 32'h4, "R10 switch flag latched");
    wr(8'h14, 32'h4);
    rd(8'h14, 32'h4, "R10 flag sticks while switch high");
    wr(8'h10, 32'h00);
    check("R9 switch low after force removed", DW'(powerSw), 0);
    wr(8'h14, 32'h4);
    rd(8'h14, 32'h0, "R7 switch flag clears");

    // R9 switch from match A, R8 interrupt stays off without enable
    wr(8'h10, 32'h44);
    wr(8'h08, 32'd7);
    wr(8'h00, 32'd7);
    check("R9 switch low before match", DW'(powerSw), 0);
    pulse();
    check("R9 switch from match A", DW'(powerSw), 1);
    check("R8 irq off without enable", DW'(irqOut), 0);
    rd(8'h14, 32'h5, "R10 switch flag with match flag");

    // R11 soft reset
    do_reset();
    wr(8'h10, 32'h40);
    wr(8'h00, 32'd19);
    wr(8'h08, 32'd19);
    wr(8'h18, 32'h1234);
    pulse();
    rd(8'h14, 32'h1, "R11 setup flag set");
    wr(8'h10, 32'h10);
    pulse();
    rd(8'h00, 32'h0, "R11 ascending cleared");
    rd(8'h04, 32'h0, "R11 descending cleared");
    rd(8'h14, 32'h0, "R11 flags cleared");
    rd(8'h08, 32'd19, "R11 match kept");
    rd(8'h18, 32'h1234, "R11 key kept");
    wr(8'h10, 32'h00);
    pulse();
    rd(8'h00, 32'd1, "R11 counting resumes");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule